// File: doc/BRIEF.md
# Extended-Precision Compare Condition-Code Unit

This block compares an 80-bit extended-precision value held in the top slot of a floating-point register stack with a second operand. The second operand is another stack register or, in test-against-zero mode, the constant +0.0. The result is written either to three status-word condition bits (C3, C2, C0) or to three integer flags (ZF, PF, CF). C1 is cleared on every compare. The block also reports invalid-operation, denormal-operand and stack-underflow conditions, and it tells the register file how many pops to perform.

The caller sets up the operands, their empty tags, the mode bits and the invalid-operation mask, then pulses `start` for one cycle. A two-state machine (`ST_IDLE`, `ST_REPORT`) registers every result on that clock edge and holds `done` high for the following cycle. It has three transitions:
- `ST_IDLE` goes to `ST_REPORT` when `start` is high.
- `ST_REPORT` stays in `ST_REPORT` when `start` is high again.
- `ST_REPORT` returns to `ST_IDLE` when `start` is low.

All result outputs hold their values until the next `start`. Format conversion of memory operands and the register file itself are outside the block.

Top module: `xcmp_cc_unit`

## Requirements
- R1: After reset, `done`, `cc`, `zf`, `pf`, `cf`, `exc_invalid`, `exc_denormal`, `stk_underflow` and `pop_cnt` are all 0.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is high, and low otherwise. All results update on that same edge.
- R3: The comparison result is encoded on {C3,C2,C0} as follows:
  - greater: 000
  - less: 001
  - equal: 100
  - unordered: 111

  `cc[i]` is Ci. +0 and −0 are equal. Finite values and infinities are ordered by sign first, then by the magnitude {exponent, significand}, with the order reversed for negative values.
- R4: Every compare clears C1 (`cc[1]`), whatever the outcome.
- R5: In the signalling compare (`quiet`=0), the result is unordered and `exc_invalid` is raised when either operand is a NaN or an unsupported encoding. An encoding is unsupported when the exponent is nonzero and the explicit integer bit (significand bit 63) is 0. A NaN has exponent all ones, integer bit 1 and a nonzero fraction; bit 62 set marks a quiet NaN and bit 62 clear marks a signalling NaN.
- R6: In the quiet compare (`quiet`=1), a NaN or unsupported operand still gives unordered, but `exc_invalid` is raised only for a signalling NaN or an unsupported encoding.
- R7: When `a_empty` is set, or `b_empty` is set outside zero mode, the block raises `stk_underflow` and `exc_invalid`. It forces the three result bits of the selected destination to 1 and clears `exc_denormal`.
- R8: With `to_flags`=1, the result is written to {ZF,PF,CF} using the R3 codes, and C3, C2 and C0 keep their previous values. With `to_flags`=0, ZF, PF and CF keep their previous values.
- R9: Outside zero mode and without underflow, `pop_cnt` equals `pop_req`, unless `exc_invalid` is raised while `im_mask`=0, in which case it is 0.
- R10: On stack underflow, `pop_cnt` equals `pop_req` if `im_mask`=1 and is 0 if `im_mask`=0. In zero mode it is always 0.
- R11: In zero mode (`use_zero`=1), the top slot is compared with +0.0 under signalling rules. `quiet`, `opb` and `b_empty` are ignored. Without underflow, `pop_cnt` equals `pop_req` regardless of exceptions.
- R12: `exc_denormal` is raised when either operand has a zero exponent and a nonzero significand, the result is not unordered, and there is no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to compare |
| opa | input | 80 | Top-slot operand |
| opb | input | 80 | Second register operand |
| a_empty | input | 1 | Top slot tagged empty |
| b_empty | input | 1 | Second register tagged empty |
| use_zero | input | 1 | Compare against +0.0 instead of opb |
| quiet | input | 1 | Quiet (unordered-tolerant) compare |
| to_flags | input | 1 | Write ZF/PF/CF instead of C3/C2/C0 |
| pop_req | input | 2 | Pops requested by the operation (0..2) |
| im_mask | input | 1 | Invalid-operation exception is masked |
| done | output | 1 | Results valid this cycle |
| cc | output | 4 | Condition bits, cc[i] = Ci |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| exc_invalid | output | 1 | Invalid-operation raised |
| exc_denormal | output | 1 | Denormal operand raised |
| stk_underflow | output | 1 | Stack underflow detected |
| pop_cnt | output | 2 | Number of stack pops to perform |

## Verification
The bench goes after several corner cases, each chosen because a plausible mistake would show up there:
- +0 against −0: a design that compared raw bits would report less instead of equal.
- Negative operands of different magnitude: a design that forgot to reverse the order would swap less and greater.
- Quiet NaNs in quiet mode: a design that did not separate quiet from signalling NaNs would raise invalid there.
- Unnormals and pseudo-infinities: a design that treated them as ordinary numbers would order them instead of reporting unordered.

The bench also checks pop suppression on both paths. On underflow it applies only when the invalid mask is clear. For an unmasked invalid it must block pops, except in zero mode, where the pop is unconditional; a design that mixed these rules would pop a stack it should keep, or keep one it should pop. In zero mode it sets `b_empty` and puts a NaN on `opb` to show that both are ignored. In flag mode it checks that the condition bits other than C1 are left untouched.

// File: rtl/xcmp_pkg.sv
package xcmp_pkg;

    // Relation codes; values chosen so that bit 0 drives C0/CF directly.
    typedef enum logic [1:0] {
        REL_GT = 2'b00,
        REL_LT = 2'b01,
        REL_EQ = 2'b10,
        REL_UN = 2'b11
    } rel_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    // Operand class flags (at most one set for a given encoding).
    typedef struct packed {
        logic zero;
        logic denorm;
        logic qnan;
        logic snan;
        logic unsup;
    } cls_t;

    // Map a relation onto the three result bits {hi, mid, lo}.
    function automatic logic [2:0] rel_bits(rel_e r);
        logic [2:0] b;
        unique case (r)
            REL_GT: b = 3'b000;
            REL_LT: b = 3'b001;
            REL_EQ: b = 3'b100;
            REL_UN: b = 3'b111;
            default: b = 3'b111;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/xcmp_classify.sv
module xcmp_classify
    import xcmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W+SIG_W-1:0] val,
    output cls_t                   cls
);
    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig_f;
    logic             exp_ones;
    logic             exp_nil;
    logic             int_bit;
    logic             qbit;
    logic             frac_nz;
    logic             low_nz;

    assign exp_f    = val[EXP_W+SIG_W-1:SIG_W];
    assign sig_f    = val[SIG_W-1:0];
    assign exp_ones = &exp_f;
    assign exp_nil  = ~|exp_f;
    assign int_bit  = sig_f[SIG_W-1];
    assign qbit     = sig_f[SIG_W-2];
    assign frac_nz  = |sig_f[SIG_W-2:0];
    assign low_nz   = |sig_f[SIG_W-3:0];

    always_comb begin
        cls        = '0;
        cls.zero   = exp_nil && !int_bit && !frac_nz;
        cls.denorm = exp_nil && (int_bit || frac_nz);
        cls.unsup  = !exp_nil && !int_bit;
        cls.qnan   = exp_ones && int_bit && qbit;
        cls.snan   = exp_ones && int_bit && !qbit && low_nz;
    end
endmodule

// File: rtl/xcmp_relate.sv
module xcmp_relate
    import xcmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W+SIG_W:0] a,
    input  logic [EXP_W+SIG_W:0] b,
    input  cls_t                 ca,
    input  cls_t                 cb,
    input  logic                 quiet,
    output rel_e                 rel,
    output logic                 invalid,
    output logic                 denorm
);
    localparam int MAG_W = EXP_W + SIG_W;

    logic             sa, sb;
    logic [MAG_W-1:0] ma, mb;
    logic             nan_any;
    logic             loud_any;

    assign sa = a[MAG_W];
    assign sb = b[MAG_W];
    assign ma = a[MAG_W-1:0];
    assign mb = b[MAG_W-1:0];

    assign nan_any  = ca.qnan | ca.snan | ca.unsup | cb.qnan | cb.snan | cb.unsup;
    assign loud_any = ca.snan | ca.unsup | cb.snan | cb.unsup;

    always_comb begin
        invalid = quiet ? loud_any : nan_any;
        denorm  = (ca.denorm | cb.denorm) && !nan_any;
        if (nan_any) begin
            rel = REL_UN;
        end else if (ca.zero && cb.zero) begin
            rel = REL_EQ;
        end else if (sa != sb) begin
            rel = sa ? REL_LT : REL_GT;
        end else if (ma == mb) begin
            rel = REL_EQ;
        end else if (ma > mb) begin
            rel = sa ? REL_LT : REL_GT;
        end else begin
            rel = sa ? REL_GT : REL_LT;
        end
    end
endmodule

// File: rtl/xcmp_cc_unit.sv
module xcmp_cc_unit
    import xcmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    parameter int POP_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [EXP_W+SIG_W:0]   opa,
    input  logic [EXP_W+SIG_W:0]   opb,
    input  logic                   a_empty,
    input  logic                   b_empty,
    input  logic                   use_zero,
    input  logic                   quiet,
    input  logic                   to_flags,
    input  logic [POP_W-1:0]       pop_req,
    input  logic                   im_mask,
    output logic                   done,
    output logic [3:0]             cc,
    output logic                   zf,
    output logic                   pf,
    output logic                   cf,
    output logic                   exc_invalid,
    output logic                   exc_denormal,
    output logic                   stk_underflow,
    output logic [POP_W-1:0]       pop_cnt
);
    localparam int W     = EXP_W + SIG_W + 1;
    localparam int N_OPS = 2;

    // ---------------- operand selection and classification ----------------
    logic [W-1:0] opnd [N_OPS];
    cls_t         cls  [N_OPS];

    assign opnd[0] = opa;
    assign opnd[1] = use_zero ? '0 : opb;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        xcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .val (opnd[gi][W-2:0]),
            .cls (cls[gi])
        );
    end

    rel_e rel_c;
    logic inv_c;
    logic den_c;
    logic quiet_eff;

    assign quiet_eff = quiet && !use_zero;

    xcmp_relate #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_rel (
        .a       (opnd[0]),
        .b       (opnd[1]),
        .ca      (cls[0]),
        .cb      (cls[1]),
        .quiet   (quiet_eff),
        .rel     (rel_c),
        .invalid (inv_c),
        .denorm  (den_c)
    );

    // ---------------- next-result computation ----------------
    logic             uflow_c;
    logic [2:0]       res_bits_c;
    logic [POP_W-1:0] pop_c;

    assign uflow_c    = a_empty || (b_empty && !use_zero);
    assign res_bits_c = uflow_c ? 3'b111 : rel_bits(rel_c);

    always_comb begin
        if (uflow_c) begin
            pop_c = (use_zero || !im_mask) ? '0 : pop_req;
        end else if (use_zero) begin
            pop_c = pop_req;
        end else begin
            pop_c = (inv_c && !im_mask) ? '0 : pop_req;
        end
    end

    // ---------------- state machine ----------------
    state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   state_n = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_n = start ? ST_REPORT : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    assign done = (state_q == ST_REPORT);

    // ---------------- result registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc            <= '0;
            zf            <= 1'b0;
            pf            <= 1'b0;
            cf            <= 1'b0;
            exc_invalid   <= 1'b0;
            exc_denormal  <= 1'b0;
            stk_underflow <= 1'b0;
            pop_cnt       <= '0;
        end else if (start) begin
            cc[1]         <= 1'b0;
            if (to_flags) begin
                {zf, pf, cf} <= res_bits_c;
            end else begin
                {cc[3], cc[2], cc[0]} <= res_bits_c;
            end
            exc_invalid   <= uflow_c | inv_c;
            exc_denormal  <= !uflow_c && den_c;
            stk_underflow <= uflow_c;
            pop_cnt       <= pop_c;
        end
    end
endmodule

// File: rtl/xcmp_cc_chk.sv
module xcmp_cc_chk #(
    parameter int POP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             use_zero,
    input logic             to_flags,
    input logic             im_mask,
    input logic             done,
    input logic [3:0]       cc,
    input logic             zf,
    input logic             pf,
    input logic             cf,
    input logic             exc_invalid,
    input logic             exc_denormal,
    input logic             stk_underflow,
    input logic [POP_W-1:0] pop_cnt
);
    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r4_c1_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cc[1]);

    a_r7_underflow_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stk_underflow) |-> exc_invalid);

    a_r12_no_denormal_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_denormal) |-> !stk_underflow);

    a_r10_unmasked_underflow_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !im_mask) |=> (!stk_underflow || pop_cnt == '0));

    a_r9_unmasked_invalid_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !im_mask && !use_zero) |=> (!exc_invalid || pop_cnt == '0));

    a_r8_flags_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !to_flags) |=> $stable({zf, pf, cf}));

    a_r8_cc_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (start && to_flags) |=> $stable({cc[3], cc[2], cc[0]}));
endmodule

bind xcmp_cc_unit xcmp_cc_chk #(.POP_W(POP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .use_zero      (use_zero),
    .to_flags      (to_flags),
    .im_mask       (im_mask),
    .done          (done),
    .cc            (cc),
    .zf            (zf),
    .pf            (pf),
    .cf            (cf),
    .exc_invalid   (exc_invalid),
    .exc_denormal  (exc_denormal),
    .stk_underflow (stk_underflow),
    .pop_cnt       (pop_cnt)
);

// File: tb/tb_xcmp_cc_unit.sv
`timescale 1ns/1ps
module tb_xcmp_cc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] opa = '0, opb = '0;
    logic        a_empty = 0, b_empty = 0, use_zero = 0, quiet = 0, to_flags = 0, im_mask = 0;
    logic [1:0]  pop_req = '0;
    logic        done;
    logic [3:0]  cc;
    logic        zf, pf, cf, exc_invalid, exc_denormal, stk_underflow;
    logic [1:0]  pop_cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic [3:0] m_cc = '0;
    logic [2:0] m_fl = '0;

    always #5 clk = ~clk;

    xcmp_cc_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .a_empty(a_empty), .b_empty(b_empty), .use_zero(use_zero), .quiet(quiet),
        .to_flags(to_flags), .pop_req(pop_req), .im_mask(im_mask), .done(done),
        .cc(cc), .zf(zf), .pf(pf), .cf(cf), .exc_invalid(exc_invalid),
        .exc_denormal(exc_denormal), .stk_underflow(stk_underflow), .pop_cnt(pop_cnt)
    );

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // class codes: 0 zero 1 denorm 2 normal 3 inf 4 qnan 5 snan 6 unsupported
    function automatic int bclass(logic [79:0] v);
        logic [14:0] e = v[78:64];
        logic [63:0] m = v[63:0];
        if (e == 15'd0) return (m == 64'd0) ? 0 : 1;
        if (!m[63]) return 6;
        if (e != 15'h7fff) return 2;
        if (m[62:0] == 63'd0) return 3;
        return m[62] ? 4 : 5;
    endfunction

    // returns {C3,C2,C0}-style bits
    function automatic logic [2:0] ref_rel(logic [79:0] a, logic [79:0] b);
        int ka = bclass(a), kb = bclass(b);
        if (ka >= 4 || kb >= 4) return 3'b111;
        if (ka == 0 && kb == 0) return 3'b100;
        if (a[79] && !b[79]) return 3'b001;
        if (!a[79] && b[79]) return 3'b000;
        if (a[78:0] == b[78:0]) return 3'b100;
        if ((a[78:0] < b[78:0]) != a[79]) return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic [79:0] mkval(int k, logic s);
        logic [62:0] r = {$urandom, $urandom};
        logic [14:0] e = 15'h3ffe + 15'($urandom % 4);
        case (k)
            0: return {s, 15'd0, 64'd0};
            1: return {s, 15'd0, 1'b0, (r == 63'd0) ? 63'd1 : r};
            2: return {s, e, 1'b1, r};
            3: return {s, 15'h7fff, 1'b1, 63'd0};
            4: return {s, 15'h7fff, 2'b11, r[61:0]};
            5: return {s, 15'h7fff, 2'b10, r[61:1], 1'b1};
            default: return ($urandom % 2) ? {s, e, 1'b0, r} : {s, 15'h7fff, 1'b0, r};
        endcase
    endfunction

    task automatic run_op(logic [79:0] a, logic [79:0] b, logic ae, logic be, logic uz,
                          logic q, logic tf, logic [1:0] pr, logic im);
        logic [79:0] bb;
        logic        uf, inv, den, nanany, loud;
        logic [2:0]  rb;
        logic [1:0]  ep;
        int          ka, kb;
        @(negedge clk);
        chk("R2 idle done", {7'd0, done}, 8'd0);
        opa = a; opb = b; a_empty = ae; b_empty = be; use_zero = uz; quiet = q;
        to_flags = tf; pop_req = pr; im_mask = im; start = 1'b1;
        // expected values
        bb = uz ? 80'd0 : b;
        ka = bclass(a); kb = bclass(bb);
        uf = ae || (be && !uz);
        nanany = (ka >= 4) || (kb >= 4);
        loud = (ka >= 5) || (kb >= 5);
        inv = uf || ((q && !uz) ? loud : nanany);
        den = !uf && !nanany && (ka == 1 || kb == 1);
        rb = uf ? 3'b111 : ref_rel(a, bb);
        if (uf) ep = (im && !uz) ? pr : 2'd0;
        else if (uz) ep = pr;
        else ep = (inv && !im) ? 2'd0 : pr;
        m_cc[1] = 1'b0;
        if (tf) m_fl = rb; else {m_cc[3], m_cc[2], m_cc[0]} = rb;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", {7'd0, done}, 8'd1);
        chk(uf ? "R7 cc" : (uz ? "R11 cc" : (tf ? "R8 cc" : "R3 cc")), {4'd0, cc}, {4'd0, m_cc});
        chk("R4 c1", {7'd0, cc[1]}, 8'd0);
        chk(uf ? "R7 flags" : "R8 flags", {5'd0, zf, pf, cf}, {5'd0, m_fl});
        chk(uf ? "R7 invalid" : (q && !uz ? "R6 invalid" : "R5 invalid"),
            {7'd0, exc_invalid}, {7'd0, inv});
        chk("R7 underflow", {7'd0, stk_underflow}, {7'd0, uf});
        chk("R12 denormal", {7'd0, exc_denormal}, {7'd0, den});
        chk(uf ? "R10 pop" : (uz ? "R11 pop" : "R9 pop"), {6'd0, pop_cnt}, {6'd0, ep});
    endtask

    localparam logic [79:0] PZERO = {1'b0, 79'd0};
    localparam logic [79:0] NZERO = {1'b1, 79'd0};
    localparam logic [79:0] ONE   = {1'b0, 15'h3fff, 1'b1, 63'd0};
    localparam logic [79:0] TWO   = {1'b0, 15'h4000, 1'b1, 63'd0};
    localparam logic [79:0] MONE  = {1'b1, 15'h3fff, 1'b1, 63'd0};
    localparam logic [79:0] MTWO  = {1'b1, 15'h4000, 1'b1, 63'd0};
    localparam logic [79:0] QNAN  = {1'b0, 15'h7fff, 2'b11, 62'd0};
    localparam logic [79:0] SNAN  = {1'b0, 15'h7fff, 2'b10, 62'd5};
    localparam logic [79:0] UNRM  = {1'b0, 15'h3fff, 1'b0, 63'd7};
    localparam logic [79:0] PINF  = {1'b0, 15'h7fff, 1'b1, 63'd0};
    localparam logic [79:0] PSINF = {1'b0, 15'h7fff, 64'd0};
    localparam logic [79:0] DEN   = {1'b0, 15'd0, 1'b0, 63'd9};

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {done, cc, zf, pf, cf}, 8'd0);
        chk("R1 reset exc", {4'd0, exc_invalid, exc_denormal, pop_cnt}, 8'd0);
        chk("R1 reset uf", {7'd0, stk_underflow}, 8'd0);
        rst_n = 1'b1;
        // directed corners
        run_op(PZERO, NZERO, 0, 0, 0, 0, 0, 2'd1, 0);   // R3 +0 == -0
        run_op(MONE, MTWO, 0, 0, 0, 0, 0, 2'd0, 0);     // R3 negative order -> greater
        run_op(ONE, TWO, 0, 0, 0, 0, 0, 2'd0, 0);       // R3 less
        run_op(PINF, TWO, 0, 0, 0, 0, 0, 2'd0, 0);      // R3 inf greater
        run_op(QNAN, ONE, 0, 0, 0, 1, 0, 2'd1, 0);      // R6 quiet qnan no invalid, pops
        run_op(SNAN, ONE, 0, 0, 0, 1, 0, 2'd1, 0);      // R6 snan invalid, no pop
        run_op(ONE, QNAN, 0, 0, 0, 0, 0, 2'd2, 0);      // R5 signalling qnan
        run_op(UNRM, ONE, 0, 0, 0, 1, 0, 2'd1, 1);      // R5/R6 unsupported, masked pop
        run_op(ONE, PSINF, 0, 0, 0, 0, 0, 2'd1, 0);     // R5 pseudo-inf
        run_op(ONE, TWO, 1, 0, 0, 0, 0, 2'd2, 1);       // R10 masked underflow pops 2
        run_op(ONE, TWO, 0, 1, 0, 0, 0, 2'd2, 0);       // R10 unmasked underflow no pop
        run_op(ONE, TWO, 0, 1, 0, 0, 1, 2'd1, 1);       // R7/R8 underflow to flags
        run_op(MONE, QNAN, 0, 1, 1, 1, 0, 2'd1, 0);     // R11 opb/b_empty ignored
        run_op(SNAN, ONE, 0, 0, 1, 1, 0, 2'd1, 0);      // R11 signalling, pops anyway
        run_op(ONE, ONE, 1, 0, 1, 0, 0, 2'd1, 1);       // R11 underflow no pop
        run_op(DEN, ONE, 0, 0, 0, 0, 0, 2'd0, 0);       // R12 denormal
        run_op(DEN, QNAN, 0, 0, 0, 1, 0, 2'd0, 1);      // R12 not on unordered
        run_op(TWO, ONE, 0, 0, 0, 0, 1, 2'd0, 0);       // R8 flags greater
        run_op(ONE, ONE, 0, 0, 0, 1, 1, 2'd1, 0);       // R8 flags equal
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            int ka = ($urandom % 10 < 6) ? int'($urandom % 3) : int'($urandom % 7);
            int kb = ($urandom % 10 < 6) ? int'($urandom % 3) : int'($urandom % 7);
            logic [79:0] a = mkval(ka, 1'($urandom));
            logic [79:0] b = ($urandom % 6 == 0) ? a : mkval(kb, 1'($urandom));
            run_op(a, b, ($urandom % 10 == 0), ($urandom % 10 == 0), ($urandom % 5 == 0),
                   1'($urandom), 1'($urandom), 2'($urandom % 3), 1'($urandom));
        end
        @(negedge clk);
        chk("R2 final idle", {7'd0, done}, 8'd0);
        finish_run();
    end
endmodule